// File: doc/BRIEF.md
# Manual Serial Pin Command Sequencer

This block lets software drive a four-lane serial link one primitive at a time while the automatic transfer engine is parked. Each command word either sets the chip-select level, pulses the serial clock once, or shifts one byte out on one, two or four data lines. A typical use is the slave resynchronisation at bring-up: select the slave, clock one byte, deselect it, then clock four more bytes with the select released.

Manual control is in force only when both the path-select input and the manual-enable input are 1. While it is off, every pin follows the automatic engine's signals, queued commands are dropped, and any primitive in progress is abandoned. Accepted commands wait in a small FIFO, so software can write them back to back. A busy flag and a one-cycle done pulse report progress.

Each clock cycle of a shift has two system-clock phases. In the first, the data sits on the lanes with the clock low. In the second, the clock is high. Data moves on when the clock falls.

Top module: `man_pin_seq`

## Requirements
- R1: After reset, with manual control active and no command issued, pinCsN is 1, pinSck is 0, pinDatOe is 0, pinDat is 0, and busy and cmdFull are 0.
- R2: Manual control is active only when manSel and manEn are both 1. Otherwise pinCsN, pinSck, pinDat and pinDatOe mirror autoCsN, autoSck, autoDat and autoDatOe, and cmdValid writes are discarded, so enabling manual control afterwards shows no queued work and no pin effect.
- R3: A command word with bit 13 clear is discarded and has no effect on busy or the pins.
- R4: Opcode field bits 11:8 select the primitive. Opcode 0x1 drives pinCsN to 0 and opcode 0x0 drives it to 1. pinCsN never changes while manual pinSck is high.
- R5: Opcode 0x2 gives exactly one pinSck rising edge, with pinSck high for one cycle and the data lanes not driven.
- R6: Opcode 0x8 shifts bits 7:0 of the command out MSB first on lane 0 in 8 clock cycles, with pinDatOe = 0001. Data is stable while pinSck is high.
- R7: Opcode 0x9 shifts the byte out on lanes 1:0 in 4 clock cycles. Each cycle's pair has the earlier bit on lane 1, and pinDatOe = 0011.
- R8: Opcode 0xA shifts the byte out on lanes 3:0 in 2 clock cycles, upper nibble first, with pinDatOe = 1111. In manual mode pinDatOe is always 0000, 0001, 0011 or 1111.
- R9: Any other opcode with bit 13 set completes with one done pulse and changes no pin.
- R10: Up to FIFO_DEPTH commands wait while one executes, and they run in arrival order. cmdFull is 1 when the queue holds FIFO_DEPTH entries, and writes made while it is full are lost.
- R11: busy is 1 while a command is queued or executing. done pulses for exactly one cycle per completed primitive.
- R12: Dropping manual control empties the queue and abandons the running primitive: busy is 0 on the following cycle, and on re-entry pinSck and pinDatOe are 0.
- R13: dualModeOut follows autoDualEn while manual control is off and is forced to 0 while it is on.
- R14: The slave-reset sequence (select low, one single-lane byte, select high, four single-lane bytes) produces 40 clock edges, with pinCsN low on exactly the first 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| manSel | input | 1 | Path select, 1 = manual path |
| manEn | input | 1 | Manual-mode enable |
| cmdValid | input | 1 | Command write strobe |
| cmdWord | input | 16 | Command: bit 13 write mark, 11:8 opcode, 7:0 data byte |
| autoCsN | input | 1 | Chip select from the automatic engine |
| autoSck | input | 1 | Serial clock from the automatic engine |
| autoDat | input | 4 | Data lanes from the automatic engine |
| autoDatOe | input | 4 | Lane output enables from the automatic engine |
| autoDualEn | input | 1 | Automatic-path dual-lane enable request |
| pinCsN | output | 1 | Chip-select pin, active low |
| pinSck | output | 1 | Serial clock pin |
| pinDat | output | 4 | Data lane pins |
| pinDatOe | output | 4 | Data lane output enables |
| dualModeOut | output | 1 | Effective automatic dual-lane enable |
| cmdFull | output | 1 | Command queue full |
| busy | output | 1 | Command queued or executing |
| done | output | 1 | One-cycle pulse when a primitive completes |

## Verification
The checker watches the framing rules on every cycle:
- the serial clock is never high for two cycles in a row;
- chip select and the data lanes hold still while the clock is high;
- the lane-enable pattern takes only the four legal shapes;
- done is a single-cycle pulse inside busy;
- a full queue implies busy;
- leaving manual mode clears busy on the next cycle.

Only the bench scenarios can show the rest. They confirm the bit order and lane assignment for every byte value in all three widths, execution order and loss of the write made while the queue is full, the discarding of non-write and inactive-mode commands, and the complete slave-reset waveform.

// File: rtl/man_seq_pkg.sv
package man_seq_pkg;
  localparam int CMD_W    = 16;
  localparam int WR_BIT   = 13;
  localparam int OP_LSB   = 8;
  localparam int OP_W     = 4;
  localparam int BYTE_W   = 8;
  localparam int LANES    = 4;
  localparam int ENTRY_W  = OP_W + BYTE_W;
  localparam int BITCNT_W = $clog2(BYTE_W);

  typedef enum logic [OP_W-1:0] {
    OP_CS_HI = 4'h0,
    OP_CS_LO = 4'h1,
    OP_CLK   = 4'h2,
    OP_SH1   = 4'h8,
    OP_SH2   = 4'h9,
    OP_SH4   = 4'hA
  } manOp_e;

  typedef struct packed {
    logic load;
    logic csHigh;
    logic csLow;
    logic sckHigh;
    logic sckLow;
    logic shift;
    logic finish;
  } seqStrobe_t;

  // number of data lanes used by an opcode (0 for non-shift primitives)
  function automatic logic [2:0] laneCount(input logic [OP_W-1:0] op);
    case (op)
      OP_SH1:  laneCount = 3'd1;
      OP_SH2:  laneCount = 3'd2;
      OP_SH4:  laneCount = 3'd4;
      default: laneCount = 3'd0;
    endcase
  endfunction

  // index of the final serial clock of a shift primitive
  function automatic logic [BITCNT_W-1:0] lastClock(input logic [OP_W-1:0] op);
    case (op)
      OP_SH1:  lastClock = BITCNT_W'(BYTE_W - 1);
      OP_SH2:  lastClock = BITCNT_W'(BYTE_W / 2 - 1);
      OP_SH4:  lastClock = BITCNT_W'(BYTE_W / 4 - 1);
      default: lastClock = '0;
    endcase
  endfunction

  function automatic logic [LANES-1:0] laneMask(input logic [2:0] width);
    case (width)
      3'd1:    laneMask = LANES'(4'b0001);
      3'd2:    laneMask = LANES'(4'b0011);
      3'd4:    laneMask = LANES'(4'b1111);
      default: laneMask = '0;
    endcase
  endfunction
endpackage

// File: rtl/man_seq_fifo.sv
module man_seq_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    bump = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/man_seq_ctrl.sv
module man_seq_ctrl
  import man_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            manActive,
  input  logic            fifoEmpty,
  input  logic [OP_W-1:0] fifoOp,
  output logic            fifoPop,
  output seqStrobe_t      strb,
  output logic            busy,
  output logic            done
);
  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_e;

  ctrlState_e          state, stateNxt;
  logic [OP_W-1:0]     opReg, opNxt;
  logic [BITCNT_W-1:0] bitCnt, cntNxt;
  logic                phase, phaseNxt;

  always_comb begin
    strb     = '0;
    fifoPop  = 1'b0;
    stateNxt = state;
    opNxt    = opReg;
    cntNxt   = bitCnt;
    phaseNxt = phase;
    if (!manActive) begin
      stateNxt = ST_IDLE;
      cntNxt   = '0;
      phaseNxt = 1'b0;
    end else if (state == ST_IDLE) begin
      if (!fifoEmpty) begin
        fifoPop   = 1'b1;
        strb.load = 1'b1;
        opNxt     = fifoOp;
        cntNxt    = '0;
        phaseNxt  = 1'b0;
        stateNxt  = ST_RUN;
      end
    end else begin
      case (opReg)
        OP_CS_HI: begin
          strb.csHigh = 1'b1;
          strb.finish = 1'b1;
          stateNxt    = ST_IDLE;
        end
        OP_CS_LO: begin
          strb.csLow  = 1'b1;
          strb.finish = 1'b1;
          stateNxt    = ST_IDLE;
        end
        OP_CLK: begin
          if (!phase) begin
            strb.sckHigh = 1'b1;
            phaseNxt     = 1'b1;
          end else begin
            strb.sckLow = 1'b1;
            strb.finish = 1'b1;
            phaseNxt    = 1'b0;
            stateNxt    = ST_IDLE;
          end
        end
        OP_SH1, OP_SH2, OP_SH4: begin
          if (!phase) begin
            strb.sckHigh = 1'b1;
            phaseNxt     = 1'b1;
          end else begin
            strb.sckLow = 1'b1;
            strb.shift  = 1'b1;
            phaseNxt    = 1'b0;
            if (bitCnt == lastClock(opReg)) begin
              strb.finish = 1'b1;
              stateNxt    = ST_IDLE;
            end else begin
              cntNxt = bitCnt + 1'b1;
            end
          end
        end
        default: begin
          strb.finish = 1'b1;
          stateNxt    = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      opReg  <= '0;
      bitCnt <= '0;
      phase  <= 1'b0;
    end else begin
      state  <= stateNxt;
      opReg  <= opNxt;
      bitCnt <= cntNxt;
      phase  <= phaseNxt;
    end
  end

  assign busy = (state == ST_RUN) || !fifoEmpty;
  assign done = strb.finish;
endmodule

// File: rtl/man_seq_dp.sv
module man_seq_dp
  import man_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              manActive,
  input  seqStrobe_t        strb,
  input  logic [OP_W-1:0]   loadOp,
  input  logic [BYTE_W-1:0] loadByte,
  input  logic              autoCsN,
  input  logic              autoSck,
  input  logic [LANES-1:0]  autoDat,
  input  logic [LANES-1:0]  autoDatOe,
  output logic              pinCsN,
  output logic              pinSck,
  output logic [LANES-1:0]  pinDat,
  output logic [LANES-1:0]  pinDatOe
);
  logic              csNReg;
  logic              sckReg;
  logic [BYTE_W-1:0] shiftReg;
  logic [2:0]        widthReg;
  logic [LANES-1:0]  oeReg;
  logic [LANES-1:0]  manDat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csNReg   <= 1'b1;
      sckReg   <= 1'b0;
      shiftReg <= '0;
      widthReg <= '0;
      oeReg    <= '0;
    end else if (!manActive) begin
      sckReg <= 1'b0;
      oeReg  <= '0;
    end else begin
      if (strb.load) begin
        shiftReg <= loadByte;
        widthReg <= laneCount(loadOp);
        oeReg    <= laneMask(laneCount(loadOp));
      end
      if (strb.csHigh)  csNReg <= 1'b1;
      if (strb.csLow)   csNReg <= 1'b0;
      if (strb.sckHigh) sckReg <= 1'b1;
      if (strb.sckLow)  sckReg <= 1'b0;
      if (strb.shift) begin
        case (widthReg)
          3'd1:    shiftReg <= shiftReg << 1;
          3'd2:    shiftReg <= shiftReg << 2;
          3'd4:    shiftReg <= shiftReg << 4;
          default: shiftReg <= shiftReg;
        endcase
      end
      if (strb.finish) oeReg <= '0;
    end
  end

  // top bits of the shift register, aligned so lane 0 carries the latest bit
  always_comb begin
    case (widthReg)
      3'd1:    manDat = LANES'(shiftReg[BYTE_W-1]);
      3'd2:    manDat = LANES'(shiftReg[BYTE_W-1 -: 2]);
      3'd4:    manDat = LANES'(shiftReg[BYTE_W-1 -: 4]);
      default: manDat = '0;
    endcase
  end

  assign pinCsN = manActive ? csNReg : autoCsN;
  assign pinSck = manActive ? sckReg : autoSck;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign pinDat[l]   = manActive ? (manDat[l] & oeReg[l]) : autoDat[l];
    assign pinDatOe[l] = manActive ? oeReg[l] : autoDatOe[l];
  end
endmodule

// File: rtl/man_pin_seq.sv
module man_pin_seq
  import man_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              manSel,
  input  logic              manEn,
  input  logic              cmdValid,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              autoCsN,
  input  logic              autoSck,
  input  logic [LANES-1:0]  autoDat,
  input  logic [LANES-1:0]  autoDatOe,
  input  logic              autoDualEn,
  output logic              pinCsN,
  output logic              pinSck,
  output logic [LANES-1:0]  pinDat,
  output logic [LANES-1:0]  pinDatOe,
  output logic              dualModeOut,
  output logic              cmdFull,
  output logic              busy,
  output logic              done
);
  logic               manActive;
  logic               cmdPush;
  logic [ENTRY_W-1:0] entryIn, entryOut;
  logic               fifoEmpty, fifoPop;
  seqStrobe_t         strb;
  logic               unusedCmdBits;

  assign manActive     = manSel && manEn;
  assign cmdPush       = cmdValid && manActive && cmdWord[WR_BIT];
  assign entryIn       = {cmdWord[OP_LSB +: OP_W], cmdWord[BYTE_W-1:0]};
  assign dualModeOut   = autoDualEn && !manActive;
  assign unusedCmdBits = ^{cmdWord[CMD_W-1:WR_BIT+1], cmdWord[WR_BIT-1:OP_LSB+OP_W]};

  man_seq_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk   (clk),
    .rstN  (rstN),
    .flush (!manActive),
    .push  (cmdPush),
    .pop   (fifoPop),
    .din   (entryIn),
    .dout  (entryOut),
    .full  (cmdFull),
    .empty (fifoEmpty)
  );

  man_seq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .manActive (manActive),
    .fifoEmpty (fifoEmpty),
    .fifoOp    (entryOut[ENTRY_W-1 -: OP_W]),
    .fifoPop   (fifoPop),
    .strb      (strb),
    .busy      (busy),
    .done      (done)
  );

  man_seq_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .manActive (manActive),
    .strb      (strb),
    .loadOp    (entryOut[ENTRY_W-1 -: OP_W]),
    .loadByte  (entryOut[BYTE_W-1:0]),
    .autoCsN   (autoCsN),
    .autoSck   (autoSck),
    .autoDat   (autoDat),
    .autoDatOe (autoDatOe),
    .pinCsN    (pinCsN),
    .pinSck    (pinSck),
    .pinDat    (pinDat),
    .pinDatOe  (pinDatOe)
  );
endmodule

// File: rtl/man_pin_seq_checker.sv
module man_pin_seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       manSel,
  input logic       manEn,
  input logic       pinCsN,
  input logic       pinSck,
  input logic [3:0] pinDat,
  input logic [3:0] pinDatOe,
  input logic       cmdFull,
  input logic       busy,
  input logic       done
);
  logic manAct;
  assign manAct = manSel && manEn;

  assert_sck_single_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (manAct && pinSck) |=> (!(manSel && manEn) || !pinSck));

  assert_cs_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (manAct && $past(manAct) && pinSck) |-> $stable(pinCsN));

  assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (manAct && $past(manAct) && pinSck) |-> $stable(pinDat));

  assert_oe_shape_R8: assert property (@(posedge clk) disable iff (!rstN)
    manAct |-> (pinDatOe == 4'b0000 || pinDatOe == 4'b0001 ||
                pinDatOe == 4'b0011 || pinDatOe == 4'b1111));

  assert_flush_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !manAct |=> !busy);

  assert_full_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdFull |-> busy);

  assert_done_in_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind man_pin_seq man_pin_seq_checker chk_i (.*);

// File: tb/man_pin_seq_tb_top.sv
module man_pin_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int DEPTH      = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       manSel = 1'b0, manEn = 1'b0;
  logic       cmdValid = 1'b0;
  logic [15:0] cmdWord = '0;
  logic       autoCsN = 1'b1, autoSck = 1'b0;
  logic [3:0] autoDat = 4'h0, autoDatOe = 4'h0;
  logic       autoDualEn = 1'b0;
  logic       pinCsN, pinSck, dualModeOut, cmdFull, busy, done;
  logic [3:0] pinDat, pinDatOe;

  int nChecks = 0;
  int nFails  = 0;

  int         edges = 0;
  int         doneCnt = 0;
  logic       lastSck = 1'b0;
  logic [3:0] capDat [64];
  logic [3:0] capOe  [64];
  logic       capCs  [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  man_pin_seq #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .manSel(manSel), .manEn(manEn),
    .cmdValid(cmdValid), .cmdWord(cmdWord),
    .autoCsN(autoCsN), .autoSck(autoSck), .autoDat(autoDat), .autoDatOe(autoDatOe),
    .autoDualEn(autoDualEn),
    .pinCsN(pinCsN), .pinSck(pinSck), .pinDat(pinDat), .pinDatOe(pinDatOe),
    .dualModeOut(dualModeOut), .cmdFull(cmdFull), .busy(busy), .done(done)
  );

  // edge monitor, sampled at the falling system clock
  always @(negedge clk) begin
    if (manSel && manEn && pinSck && !lastSck) begin
      if (edges < 64) begin
        capDat[edges] = pinDat;
        capOe[edges]  = pinDatOe;
        capCs[edges]  = pinCsN;
      end
      edges = edges + 1;
    end
    lastSck = pinSck;
    if (done) doneCnt = doneCnt + 1;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pushCmd(input logic [3:0] op, input logic [7:0] b, input bit wr);
    cmdWord  = {2'b00, wr, 1'b0, op, b};
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  task automatic clearCap();
    edges   = 0;
    doneCnt = 0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R11 watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin : main
    int val;
    bit oeOk;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 / R13: inactive mode mirrors the automatic side
    autoCsN = 1'b0; autoSck = 1'b1; autoDat = 4'hA; autoDatOe = 4'h5; autoDualEn = 1'b1;
    @(negedge clk);
    check(pinCsN == 1'b0 && pinSck == 1'b1, "R2", "cs/sck mirror auto", {pinCsN, pinSck}, 2'b01);
    check(pinDat == 4'hA && pinDatOe == 4'h5, "R2", "lanes mirror auto", {pinDat, pinDatOe}, 8'hA5);
    check(dualModeOut == 1'b1, "R13", "dual follows auto when inactive", dualModeOut, 1);
    check(busy == 1'b0 && cmdFull == 1'b0, "R1", "busy/full after reset", {busy, cmdFull}, 0);

    // R2: commands written while inactive are discarded
    manSel = 1'b1;
    pushCmd(4'h1, 8'h00, 1'b1);
    manEn = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R2", "inactive write left no work", busy, 0);

    // R1: manual reset state
    check(pinCsN == 1'b1 && pinSck == 1'b0, "R1", "manual cs/sck reset", {pinCsN, pinSck}, 2'b10);
    check(pinDatOe == 4'h0 && pinDat == 4'h0, "R1", "manual lanes reset", {pinDat, pinDatOe}, 0);
    check(dualModeOut == 1'b0, "R13", "dual forced off in manual", dualModeOut, 0);

    // R4: chip select control
    pushCmd(4'h1, 8'h00, 1'b1);
    waitIdle();
    check(pinCsN == 1'b0, "R4", "cs low opcode", pinCsN, 0);
    pushCmd(4'h0, 8'h00, 1'b1);
    waitIdle();
    check(pinCsN == 1'b1, "R4", "cs high opcode", pinCsN, 1);

    // R5: single clock pulse
    clearCap();
    pushCmd(4'h2, 8'hFF, 1'b1);
    waitIdle();
    check(edges == 1, "R5", "clock pulse edges", edges, 1);
    check(capOe[0] == 4'h0, "R5", "lanes idle on pulse", capOe[0], 0);
    check(doneCnt == 1, "R11", "one done per pulse", doneCnt, 1);

    // R6/R7/R8: exhaustive byte sweep in all three widths
    for (int wi = 0; wi < 3; wi++) begin
      int w = 1 << wi;
      logic [3:0] op = 4'h8 + 4'(wi);
      logic [3:0] msk = 4'((1 << w) - 1);
      string req = (wi == 0) ? "R6" : (wi == 1) ? "R7" : "R8";
      for (int b = 0; b < 256; b++) begin
        clearCap();
        pushCmd(op, 8'(b), 1'b1);
        waitIdle();
        val = 0;
        oeOk = 1'b1;
        for (int k = 0; k < edges && k < 64; k++) begin
          val = (val << w) | int'(capDat[k] & msk);
          if (capOe[k] != msk) oeOk = 1'b0;
        end
        check(edges == 8 / w, req, "clock count", edges, 8 / w);
        check(val == b && oeOk, req, "shifted byte", val, b);
      end
    end

    // R3: non-write command discarded
    pushCmd(4'h1, 8'h00, 1'b0);
    check(busy == 1'b0, "R3", "no work from non-write", busy, 0);
    @(negedge clk);
    check(pinCsN == 1'b1, "R3", "cs untouched by non-write", pinCsN, 1);

    // R9: undefined opcode completes without pin effect
    clearCap();
    pushCmd(4'h5, 8'hC3, 1'b1);
    waitIdle();
    check(edges == 0 && pinCsN == 1'b1 && pinDatOe == 4'h0, "R9", "undefined opcode pins",
          {edges[7:0], pinCsN, pinDatOe}, 8'h0 << 5 | 5'h10);
    check(doneCnt == 1, "R9", "undefined opcode done count", doneCnt, 1);

    // R10/R11: back-to-back writes, queue fills, sixth write lost
    clearCap();
    for (int i = 0; i < 6; i++) begin
      if (i == 2) check(busy == 1'b1, "R11", "busy while queued", busy, 1);
      if (i == 5) check(cmdFull == 1'b1, "R10", "queue full after five writes", cmdFull, 1);
      cmdWord  = {2'b00, 1'b1, 1'b0, 4'h8, 8'(8'h3C + 8'(i) * 8'h11)};
      cmdValid = 1'b1;
      @(negedge clk);
    end
    cmdValid = 1'b0;
    waitIdle();
    check(edges == 40, "R10", "five commands executed", edges, 40);
    check(doneCnt == 5, "R11", "done pulses", doneCnt, 5);
    for (int i = 0; i < 5; i++) begin
      val = 0;
      for (int k = 0; k < 8; k++) val = (val << 1) | int'(capDat[i*8 + k][0]);
      check(val == int'(8'(8'h3C + 8'(i) * 8'h11)), "R10", "arrival order", val,
            int'(8'(8'h3C + 8'(i) * 8'h11)));
    end

    // R12: dropping manual mode flushes and aborts
    pushCmd(4'h8, 8'hFF, 1'b1);
    pushCmd(4'h8, 8'hAA, 1'b1);
    pushCmd(4'h1, 8'h00, 1'b1);
    repeat (3) @(negedge clk);
    manEn = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R12", "busy cleared after exit", busy, 0);
    check(pinSck == autoSck && pinCsN == autoCsN, "R12", "pins back to auto",
          {pinSck, pinCsN}, {autoSck, autoCsN});
    manEn = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && pinSck == 1'b0 && pinDatOe == 4'h0, "R12", "clean re-entry",
          {busy, pinSck, pinDatOe}, 0);
    check(pinCsN == 1'b1, "R12", "flushed cs-low never ran", pinCsN, 1);

    // R14: slave-reset sequence
    clearCap();
    pushCmd(4'h1, 8'hFF, 1'b1); waitIdle();
    pushCmd(4'h8, 8'hFF, 1'b1); waitIdle();
    pushCmd(4'h0, 8'hFF, 1'b1); waitIdle();
    for (int i = 0; i < 4; i++) begin
      pushCmd(4'h8, 8'hFF, 1'b1);
      waitIdle();
    end
    check(edges == 40, "R14", "reset sequence edges", edges, 40);
    val = 0;
    for (int k = 0; k < 40; k++) if (capCs[k] == (k < 8)) val++;
    check(val == 0, "R14", "cs low only for first byte", val, 0);
    check(pinCsN == 1'b1 && doneCnt == 7, "R14", "final cs and done count",
          {pinCsN, doneCnt[7:0]}, {1'b1, 8'd7});

    summary();
  end
endmodule